// File: doc/BRIEF.md
# Receive Buffer Credit Counter with Hysteresis Back-Pressure

This block keeps a running count of the receive buffers that software has made available to one receive channel, and drives a back-pressure flag from that count. Software hands buffers back by writing a credit amount to an allocation register. It can also overwrite the count outright by setting bit 31 of that write, which is the path used while a channel is shut down. Each time the receive channel takes a descriptor, it pulses a consume input and the count drops by one.

The flag follows a hysteresis rule set by two programmable thresholds. It rises once the count falls under the lower threshold. It clears only after the count climbs past the upper threshold, and inside that band it keeps its last value. Software usually sets the thresholds to about a third and two thirds of the ring size.

One instance serves one channel pair, chosen by parameter `UNIT_IDX`. A shared configuration word at offset 0x00 holds two enables: an engine enable in bit 0 and this unit's own enable in bit `UNIT_IDX+1`. The unit has three registers, at offsets 0x04, 0x08 and 0x0C plus 0x0C times `UNIT_IDX`.

Top module: `rx_credit_fc`

## Requirements
- R1: After reset the available count is 0, the back-pressure flag is 0, both thresholds are 0 and both enables are off.
- R2: A write to the allocation register (offset 0x0C + 0x0C*UNIT_IDX) with bit 31 clear adds the value in bits [CNT_W-1:0] to the count. The count is visible one clock after the write, whatever the enables are.
- R3: A write to the allocation register with bit 31 set loads the count with bits [CNT_W-1:0]. A consume pulse in the same cycle is ignored.
- R4: A consume pulse on an enabled unit lowers the count by one, and the count stays at 0 rather than wrapping below it.
- R5: The count saturates at 2^CNT_W-1 and never wraps upward.
- R6: A credit write of n and a consume pulse in the same cycle move the count by n-1, with R4 and R5 saturation applied to that net result.
- R7: When the unit is enabled and the count is below the low threshold (offset 0x04 + 0x0C*UNIT_IDX), the flag is 1 one clock after the count register holds that value.
- R8: Once set, the flag stays 1 while the count is at or below the high threshold (offset 0x08 + 0x0C*UNIT_IDX). It clears one clock after the count exceeds that threshold. Inside the band the flag keeps its previous value.
- R9: The unit is enabled only when bit 0 and bit UNIT_IDX+1 of the word at offset 0x00 are both 1. While it is disabled the flag is 0 and consume pulses leave the count unchanged.
- R10: Writes to offsets that do not belong to this unit, including another unit's allocation register, leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| consume | input | 1 | One-cycle pulse for each descriptor the channel takes |
| fc_assert | output | 1 | Back-pressure flag |
| avail_cnt | output | CNT_W | Current available buffer count |

## Verification
The count is driven down across the low threshold, then back up through the band one credit at a time and past the high threshold. This separates a plain comparator from true hysteresis, because the flag must hold at exactly the high threshold and clear only one credit above it. Same-cycle credit-and-consume is tried both in mid-range and at the top of the range, which exposes a design that saturates before netting out the two. Forced loads with a simultaneous consume, consumes at zero, consumes while disabled, and a write to the neighbouring unit's allocation offset each show a different way the count could be disturbed when it should not be.

// File: rtl/rx_credit_pkg.sv
package rx_credit_pkg;
  localparam int unsigned CFG_OFS    = 0;
  localparam int unsigned UNIT_BASE  = 4;
  localparam int unsigned UNIT_STRIDE = 12;
  localparam int unsigned FORCE_BIT  = 31;

  typedef struct packed {
    logic        hit;
    logic        force_ld;
    logic [31:0] value;
  } alloc_req_t;
endpackage

// File: rtl/rx_credit_regs.sv
module rx_credit_regs
  import rx_credit_pkg::*;
#(
  parameter int unsigned UNIT_IDX = 1,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              unit_on,
  output logic [CNT_W-1:0]  thr_lo,
  output logic [CNT_W-1:0]  thr_hi,
  output alloc_req_t        alloc
);
  localparam int unsigned LO_OFS    = UNIT_BASE + UNIT_STRIDE * UNIT_IDX;
  localparam int unsigned HI_OFS    = LO_OFS + 4;
  localparam int unsigned ALLOC_OFS = LO_OFS + 8;
  localparam int unsigned EN_BIT    = UNIT_IDX + 1;

  logic cfg_hit, lo_hit, hi_hit, alloc_hit;
  logic eng_en_q, pair_en_q;

  assign cfg_hit   = reg_wr && (reg_addr == ADDR_W'(CFG_OFS));
  assign lo_hit    = reg_wr && (reg_addr == ADDR_W'(LO_OFS));
  assign hi_hit    = reg_wr && (reg_addr == ADDR_W'(HI_OFS));
  assign alloc_hit = reg_wr && (reg_addr == ADDR_W'(ALLOC_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_en_q  <= 1'b0;
      pair_en_q <= 1'b0;
      thr_lo    <= '0;
      thr_hi    <= '0;
    end else begin
      if (cfg_hit) begin
        eng_en_q  <= reg_wdata[0];
        pair_en_q <= reg_wdata[EN_BIT];
      end
      if (lo_hit) thr_lo <= reg_wdata[CNT_W-1:0];
      if (hi_hit) thr_hi <= reg_wdata[CNT_W-1:0];
    end
  end

  assign unit_on        = eng_en_q && pair_en_q;
  assign alloc.hit      = alloc_hit;
  assign alloc.force_ld = reg_wdata[FORCE_BIT];
  assign alloc.value    = reg_wdata;

  // R10: at most one register is selected by any write
  a_r10_decode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_hit, lo_hit, hi_hit, alloc_hit}));
endmodule

// File: rtl/rx_credit_counter.sv
module rx_credit_counter
  import rx_credit_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_on,
  input  logic             consume,
  input  alloc_req_t       alloc,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] add,
                                                input logic take);
    logic [CNT_W+1:0] wide;
    wide = {2'b00, cur} + {2'b00, add} - {{(CNT_W+1){1'b0}}, take};
    if (wide[CNT_W+1])   return '0;
    else if (wide[CNT_W]) return CNT_MAX;
    else                  return wide[CNT_W-1:0];
  endfunction

  logic             take_ev;
  logic             force_ev;
  logic [CNT_W-1:0] credit;
  logic [CNT_W-1:0] cnt_d;
  logic             unused_bits;

  assign take_ev     = consume && unit_on;
  assign force_ev    = alloc.hit && alloc.force_ld;
  assign credit      = (alloc.hit && !alloc.force_ld) ? alloc.value[CNT_W-1:0] : '0;
  assign unused_bits = ^alloc.value[31:CNT_W];

  always_comb begin
    if (force_ev) cnt_d = alloc.value[CNT_W-1:0];
    else          cnt_d = sat_step(cnt_q, credit, take_ev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r3_force_load: assert property (@(posedge clk) disable iff (!rst_n)
    force_ev |=> cnt_q == $past(alloc.value[CNT_W-1:0]));
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !alloc.hit) |=> cnt_q == '0);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && alloc.hit && !alloc.force_ld && !consume) |=> cnt_q == CNT_MAX);
  a_r9_consume_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_on && !alloc.hit) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_credit_hyst.sv
module rx_credit_hyst #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_on,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thr_lo,
  input  logic [CNT_W-1:0] thr_hi,
  output logic             fc_q
);
  logic below_lo, above_hi;

  assign below_lo = cnt < thr_lo;
  assign above_hi = cnt > thr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fc_q <= 1'b0;
    else if (!unit_on) fc_q <= 1'b0;
    else if (below_lo) fc_q <= 1'b1;
    else if (above_hi) fc_q <= 1'b0;
  end

  a_r7_assert_low: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_on && below_lo) |=> fc_q);
  a_r8_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_on && fc_q && !above_hi) |=> fc_q);
  a_r8_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!fc_q && !below_lo) |=> !fc_q);
  a_r9_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_on |=> !fc_q);
endmodule

// File: rtl/rx_credit_fc.sv
module rx_credit_fc
  import rx_credit_pkg::*;
#(
  parameter int unsigned UNIT_IDX = 1,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              consume,
  output logic              fc_assert,
  output logic [CNT_W-1:0]  avail_cnt
);
  logic             unit_on;
  logic [CNT_W-1:0] thr_lo, thr_hi;
  alloc_req_t       alloc;

  rx_credit_regs #(.UNIT_IDX(UNIT_IDX), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .unit_on(unit_on), .thr_lo(thr_lo),
    .thr_hi(thr_hi), .alloc(alloc));

  rx_credit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .unit_on(unit_on), .consume(consume),
    .alloc(alloc), .cnt_q(avail_cnt));

  rx_credit_hyst #(.CNT_W(CNT_W)) u_hyst (
    .clk(clk), .rst_n(rst_n), .unit_on(unit_on), .cnt(avail_cnt),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .fc_q(fc_assert));

  // R1: outputs clear in the first cycle after reset release
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (avail_cnt == '0 && !fc_assert));
endmodule

// File: tb/rx_credit_fc_tb.sv
module rx_credit_fc_tb;
  localparam int CW = 6;
  localparam int U  = 1;
  localparam logic [7:0] A_CFG   = 8'h00;
  localparam logic [7:0] A_LO    = 8'(4 + 12*U);
  localparam logic [7:0] A_HI    = 8'(8 + 12*U);
  localparam logic [7:0] A_ALLOC = 8'(12 + 12*U);
  localparam logic [7:0] A_OTHER = 8'h0C;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, consume = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic fc_assert;
  logic [CW-1:0] avail_cnt;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  rx_credit_fc #(.UNIT_IDX(U), .CNT_W(CW), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .consume(consume), .fc_assert(fc_assert),
    .avail_cnt(avail_cnt));

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge; on return one posedge has passed, so the count is updated
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic c);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; consume = c;
    @(negedge clk);
    reg_wr = 1'b0; consume = 1'b0;
  endtask

  task automatic settle_fc;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 count", int'(avail_cnt), 0);
    check("R1 flag", int'(fc_assert), 0);
  endtask

  task automatic t_disabled;
    step(1, A_ALLOC, 32'd3, 0);
    check("R2 credit add", int'(avail_cnt), 3);
    step(0, A_CFG, 0, 1);
    check("R9 consume ignored when off", int'(avail_cnt), 3);
    step(1, A_CFG, 32'h1, 1);
    check("R9 engine only, consume ignored", int'(avail_cnt), 3);
    step(1, A_OTHER, 32'd5, 0);
    check("R10 other unit alloc", int'(avail_cnt), 3);
  endtask

  task automatic t_hysteresis;
    step(1, A_LO, 32'd2, 0);
    step(1, A_HI, 32'd4, 0);
    step(1, A_CFG, 32'h5, 0);
    settle_fc();
    check("R8 band holds clear", int'(fc_assert), 0);
    step(0, A_CFG, 0, 1);
    check("R4 decrement", int'(avail_cnt), 2);
    settle_fc();
    check("R7 not below lo", int'(fc_assert), 0);
    step(0, A_CFG, 0, 1);
    settle_fc();
    check("R7 below lo", int'(fc_assert), 1);
    step(1, A_ALLOC, 32'd2, 0);
    settle_fc();
    check("R8 hold in band", int'(fc_assert), 1);
    step(1, A_ALLOC, 32'd1, 0);
    settle_fc();
    check("R8 hold at hi", int'(fc_assert), 1);
    step(1, A_ALLOC, 32'd1, 0);
    settle_fc();
    check("R8 clear above hi", int'(fc_assert), 0);
    step(0, A_CFG, 0, 1);
    settle_fc();
    check("R8 band keeps clear", int'(fc_assert), 0);
  endtask

  task automatic t_net_and_sat;
    step(1, A_ALLOC, 32'd3, 1);
    check("R6 net credit", int'(avail_cnt), 6);
    step(1, A_ALLOC, 32'h8000_000A, 1);
    check("R3 force overrides consume", int'(avail_cnt), 10);
    step(1, A_ALLOC, 32'h8000_003E, 0);
    step(1, A_ALLOC, 32'd5, 0);
    check("R5 saturate top", int'(avail_cnt), 63);
    step(1, A_ALLOC, 32'd1, 1);
    check("R6 net at top", int'(avail_cnt), 63);
    step(0, A_CFG, 0, 1);
    check("R4 decrement from top", int'(avail_cnt), 62);
    step(1, A_ALLOC, 32'h8000_0000, 0);
    check("R3 force zero", int'(avail_cnt), 0);
    step(0, A_CFG, 0, 1);
    check("R4 floor at zero", int'(avail_cnt), 0);
    settle_fc();
    check("R7 flag at zero", int'(fc_assert), 1);
    step(1, A_CFG, 32'h1, 0);
    settle_fc();
    check("R9 flag off when unit disabled", int'(fc_assert), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_hysteresis();
    t_net_and_sat();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule